// File: doc/BRIEF.md
# PC Card Attribute Memory Responder

This block answers a PC Card host's accesses to attribute memory. When the host selects attribute space and reads, the block returns a fixed card information structure from an internal ROM. That structure is a chain of tuples that describes the card to the host's card services. The block also holds one writable configuration option register. The host writes a configuration index there to move the card from memory-only operation to its combined memory-and-I/O interface.

The host strobes (REG#, CE1#, CE2#, OE#, WE#) arrive with no relation to the local clock. They pass through a multi-stage synchronizer before any decision uses them. The address and write data are registered every cycle and are assumed stable while a strobe is held. Read data leaves through a registered output with separate lane enables, so that a pad ring can build the tri-state 16-bit bus. Structure bytes appear only at even byte addresses, on the low data lane.

Top module: `pccard_attr_resp`

## Requirements
- R1: While `rst` is high and after it, both lane enables are low, `cfg_index` is 0 and `io_enable` is 0.
- R2: The low lane enable rises only for a read with REG#, CE1# and OE# all low. If REG# is high or CE1# is high, nothing is driven.
- R3: The high lane enable is high only when the low lane enable is high and CE2# is also low. The high data byte then reads 0x00.
- R4: Strobes are set up before a rising clock edge. The enable and valid read data appear after the third rising edge and not after the second. After the strobes are released, the enables fall after the third rising edge and not before.
- R5: Structure byte k (k = 0..42) is read on the low lane at byte address 2k. In order, the bytes are: 01 03 D4 00 FF; 15 10 04 01 4D 53 53 00 43 4F 4D 20 31 33 30 30 00 FF; 20 04 00 00 01 01; 1A 05 01 01 00 02 01; 1B 04 C1 01 08 46; FF.
- R6: A read at an odd address reads 0xFF on the low lane. So does a read at an even address of 86 or above, other than 0x200.
- R7: The configuration option register sits at byte address 0x200. A write is accepted when REG# and CE1# are low and OE# is high, as WE# goes low. The write takes the low data byte. A read at 0x200 returns all 8 stored bits.
- R8: `cfg_index` shows the low 6 bits of the configuration register. `io_enable` is high exactly when that index equals 1.
- R9: A write attempt leaves the register unchanged in each of these cases: REG# is high, CE1# is high, the address is not 0x200, or OE# is low at the same time.
- R10: A synchronous reset returns a previously written register to 0 and clears `io_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host byte address |
| host_reg_n | input | 1 | Attribute space select, active low |
| host_ce1_n | input | 1 | Low (even) byte lane enable, active low |
| host_ce2_n | input | 1 | High (odd) byte lane enable, active low |
| host_oe_n | input | 1 | Read strobe, active low |
| host_we_n | input | 1 | Write strobe, active low |
| host_wdata | input | 8 | Low lane write data |
| host_rdata | output | 16 | Read data toward the pads |
| host_rdata_oe_lo | output | 1 | Drive enable for bits 7:0 |
| host_rdata_oe_hi | output | 1 | Drive enable for bits 15:8 |
| cfg_index | output | IDX_W | Current configuration index |
| io_enable | output | 1 | Memory-and-I/O interface selected |

## Verification
The hardest case to bring about is a rejected write. From the ports it looks exactly like an accepted one that happened to store the same value. To tell them apart, the bench first loads a distinctive nonzero value into the configuration register. It then makes each rejected attempt: wrong space, missing lane enable, wrong address, or OE# held low together with WE#. After each attempt it reads address 0x200 back through the attribute window and checks the index outputs. For the access time, every read samples the enable both one edge before and at the promised edge, on the assert side and on the release side.

// File: rtl/pcc_attr_pkg.sv
package pcc_attr_pkg;

  // Number of bytes in the card information structure.
  localparam int CIS_LEN = 43;

  // Structure byte k; bytes past the end read as the terminator value.
  function automatic logic [7:0] cis_byte(input int k);
    logic [7:0] b;
    case (k)
      // device information tuple
      0:  b = 8'h01;  1:  b = 8'h03;  2:  b = 8'hD4;  3:  b = 8'h00;
      4:  b = 8'hFF;
      // version / product strings tuple
      5:  b = 8'h15;  6:  b = 8'h10;  7:  b = 8'h04;  8:  b = 8'h01;
      9:  b = 8'h4D;  10: b = 8'h53;  11: b = 8'h53;  12: b = 8'h00;
      13: b = 8'h43;  14: b = 8'h4F;  15: b = 8'h4D;  16: b = 8'h20;
      17: b = 8'h31;  18: b = 8'h33;  19: b = 8'h30;  20: b = 8'h30;
      21: b = 8'h00;  22: b = 8'hFF;
      // manufacturer identity tuple
      23: b = 8'h20;  24: b = 8'h04;  25: b = 8'h00;  26: b = 8'h00;
      27: b = 8'h01;  28: b = 8'h01;
      // configuration tuple: base 0x0200, mask selects option register
      29: b = 8'h1A;  30: b = 8'h05;  31: b = 8'h01;  32: b = 8'h01;
      33: b = 8'h00;  34: b = 8'h02;  35: b = 8'h01;
      // configuration table entry: index 1, memory-or-I/O, 8-bit I/O range
      36: b = 8'h1B;  37: b = 8'h04;  38: b = 8'hC1;  39: b = 8'h01;
      40: b = 8'h08;  41: b = 8'h46;
      // end of chain
      default: b = 8'hFF;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/pcc_sync.sv
module pcc_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pcc_cis_rom.sv
module pcc_cis_rom
  import pcc_attr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);

  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_fill
    assign mem[i] = cis_byte(i);
  end

  // Registered read, no reset: maps onto a block RAM read port.
  always_ff @(posedge clk) begin
    rd_byte <= mem[rd_idx];
  end

endmodule

// File: rtl/pcc_cor_reg.sv
module pcc_cor_reg #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  output logic [7:0]       cor_q,
  output logic             io_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cor_q <= '0;
      io_en <= 1'b0;
    end else if (wr_en) begin
      cor_q <= wr_byte;
      io_en <= (wr_byte[IDX_W-1:0] == IDX_W'(1));
    end
  end

endmodule

// File: rtl/pccard_attr_resp.sv
module pccard_attr_resp
  import pcc_attr_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          SYNC_STAGES = 2,
  parameter int          ROM_DEPTH   = 64,
  parameter int unsigned COR_ADDR    = 32'h200,
  parameter int          IDX_W       = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_reg_n,
  input  logic              host_ce1_n,
  input  logic              host_ce2_n,
  input  logic              host_oe_n,
  input  logic              host_we_n,
  input  logic [7:0]        host_wdata,
  output logic [15:0]       host_rdata,
  output logic              host_rdata_oe_lo,
  output logic              host_rdata_oe_hi,
  output logic [IDX_W-1:0]  cfg_index,
  output logic              io_enable
);

  localparam int ROM_IW = $clog2(ROM_DEPTH);
  localparam int WORD_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] COR_A = ADDR_W'(COR_ADDR);
  localparam logic [WORD_W-1:0] CIS_WORDS = WORD_W'(CIS_LEN);
  localparam int NSTRB = 5;
  localparam int S_REG = 4;
  localparam int S_CE1 = 3;
  localparam int S_CE2 = 2;
  localparam int S_OE  = 1;
  localparam int S_WE  = 0;

  // ---------------- strobe synchronizer ----------------
  logic [NSTRB-1:0] strb_raw;
  logic [NSTRB-1:0] strb_s;

  assign strb_raw = {~host_reg_n, ~host_ce1_n, ~host_ce2_n, ~host_oe_n, ~host_we_n};

  pcc_sync #(.W(NSTRB), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (strb_raw),
    .q   (strb_s)
  );

  logic rd_lo_s;
  logic rd_hi_s;
  assign rd_lo_s = strb_s[S_REG] & strb_s[S_CE1] & strb_s[S_OE];
  assign rd_hi_s = rd_lo_s & strb_s[S_CE2];

  // ---------------- address and write data capture ----------------
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
    end
  end

  logic hit_cor;
  logic hit_rom;
  assign hit_cor = (addr_q == COR_A);
  assign hit_rom = (addr_q[ADDR_W-1:1] < CIS_WORDS);

  // ---------------- configuration option register ----------------
  logic we_prev;
  logic cor_we;
  logic [7:0] cor_q;

  always_ff @(posedge clk) begin
    if (rst) we_prev <= 1'b0;
    else     we_prev <= strb_s[S_WE];
  end

  assign cor_we = strb_s[S_WE] & ~we_prev & strb_s[S_REG] & strb_s[S_CE1]
                & ~strb_s[S_OE] & hit_cor;

  pcc_cor_reg #(.IDX_W(IDX_W)) u_cor (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cor_we),
    .wr_byte (wdata_q),
    .cor_q   (cor_q),
    .io_en   (io_enable)
  );

  assign cfg_index = cor_q[IDX_W-1:0];

  // ---------------- structure ROM (stage A) ----------------
  logic [7:0] rom_q;

  pcc_cis_rom #(.DEPTH(ROM_DEPTH), .IW(ROM_IW)) u_rom (
    .clk     (clk),
    .rd_idx  (addr_q[ROM_IW:1]),
    .rd_byte (rom_q)
  );

  logic odd_d;
  logic cor_d;
  logic rom_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_d <= 1'b0;
      cor_d <= 1'b0;
      rom_d <= 1'b0;
    end else begin
      odd_d <= addr_q[0];
      cor_d <= hit_cor;
      rom_d <= hit_rom;
    end
  end

  // ---------------- output stage B ----------------
  logic [7:0] lo_next;

  always_comb begin
    if (odd_d)      lo_next = 8'hFF;
    else if (cor_d) lo_next = cor_q;
    else if (rom_d) lo_next = rom_q;
    else            lo_next = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata       <= '0;
      host_rdata_oe_lo <= 1'b0;
      host_rdata_oe_hi <= 1'b0;
    end else begin
      host_rdata       <= {8'h00, lo_next};
      host_rdata_oe_lo <= rd_lo_s;
      host_rdata_oe_hi <= rd_hi_s;
    end
  end

endmodule

// File: rtl/pccard_attr_resp_chk.sv
module pccard_attr_resp_chk #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       host_rdata,
  input logic              host_rdata_oe_lo,
  input logic              host_rdata_oe_hi,
  input logic [IDX_W-1:0]  cfg_index,
  input logic              io_enable,
  input logic              rd_lo_s,
  input logic              cor_we,
  input logic [ADDR_W-1:0] addr_q
);

  // R3: the high lane is never driven on its own
  assert_hi_needs_lo_R3: assert property (@(posedge clk) disable iff (rst)
    host_rdata_oe_hi |-> host_rdata_oe_lo);

  // R3: the high data byte reads zero whenever it is driven
  assert_hi_byte_zero_R3: assert property (@(posedge clk) disable iff (rst)
    host_rdata_oe_hi |-> host_rdata[15:8] == 8'h00);

  // R2 / R4: the enable follows the synchronized select one edge later
  assert_oe_from_select_R2: assert property (@(posedge clk) disable iff (rst)
    host_rdata_oe_lo |-> $past(rd_lo_s));
  assert_select_to_oe_R4: assert property (@(posedge clk) disable iff (rst)
    $past(rd_lo_s) |-> host_rdata_oe_lo);

  // R6: odd addresses read 0xFF
  assert_odd_reads_ff_R6: assert property (@(posedge clk) disable iff (rst)
    (host_rdata_oe_lo && $past(addr_q[0])) |-> host_rdata[7:0] == 8'hFF);

  // R9: the index moves only after an accepted write
  assert_cfg_only_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_index) |-> $past(cor_we));

  // R8: io_enable tracks index value 1
  assert_io_when_index1_R8: assert property (@(posedge clk) disable iff (rst)
    io_enable |-> cfg_index == IDX_W'(1));
  assert_index1_gives_io_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_index == IDX_W'(1)) |-> io_enable);

endmodule

bind pccard_attr_resp pccard_attr_resp_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .host_rdata       (host_rdata),
  .host_rdata_oe_lo (host_rdata_oe_lo),
  .host_rdata_oe_hi (host_rdata_oe_hi),
  .cfg_index        (cfg_index),
  .io_enable        (io_enable),
  .rd_lo_s          (rd_lo_s),
  .cor_we           (cor_we),
  .addr_q           (addr_q)
);

// File: tb/pccard_attr_resp_test.sv
`timescale 1ns/1ps
module pccard_attr_resp_test;

  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic          host_reg_n = 1'b1;
  logic          host_ce1_n = 1'b1;
  logic          host_ce2_n = 1'b1;
  logic          host_oe_n  = 1'b1;
  logic          host_we_n  = 1'b1;
  logic [7:0]    host_wdata = '0;
  logic [15:0]   host_rdata;
  logic          host_rdata_oe_lo;
  logic          host_rdata_oe_hi;
  logic [5:0]    cfg_index;
  logic          io_enable;

  int checks = 0;
  int errors = 0;
  logic [7:0] cor_model = 8'h00;

  always #4 clk = ~clk;

  pccard_attr_resp uut (
    .clk              (clk),
    .rst              (rst),
    .host_addr        (host_addr),
    .host_reg_n       (host_reg_n),
    .host_ce1_n       (host_ce1_n),
    .host_ce2_n       (host_ce2_n),
    .host_oe_n        (host_oe_n),
    .host_we_n        (host_we_n),
    .host_wdata       (host_wdata),
    .host_rdata       (host_rdata),
    .host_rdata_oe_lo (host_rdata_oe_lo),
    .host_rdata_oe_hi (host_rdata_oe_hi),
    .cfg_index        (cfg_index),
    .io_enable        (io_enable)
  );

  function automatic logic [7:0] exp_cis(input int k);
    case (k)
      0: return 8'h01;  1: return 8'h03;  2: return 8'hD4;  3: return 8'h00;
      4: return 8'hFF;  5: return 8'h15;  6: return 8'h10;  7: return 8'h04;
      8: return 8'h01;  9: return 8'h4D;  10: return 8'h53; 11: return 8'h53;
      12: return 8'h00; 13: return 8'h43; 14: return 8'h4F; 15: return 8'h4D;
      16: return 8'h20; 17: return 8'h31; 18: return 8'h33; 19: return 8'h30;
      20: return 8'h30; 21: return 8'h00; 22: return 8'hFF; 23: return 8'h20;
      24: return 8'h04; 25: return 8'h00; 26: return 8'h00; 27: return 8'h01;
      28: return 8'h01; 29: return 8'h1A; 30: return 8'h05; 31: return 8'h01;
      32: return 8'h01; 33: return 8'h00; 34: return 8'h02; 35: return 8'h01;
      36: return 8'h1B; 37: return 8'h04; 38: return 8'hC1; 39: return 8'h01;
      40: return 8'h08; 41: return 8'h46; 42: return 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  // R5 / R6 / R7 expected low byte for an address
  function automatic logic [7:0] exp_byte(input logic [AW-1:0] a);
    if (a[0])            return 8'hFF;
    if (a == 12'h200)    return cor_model;
    if ((a >> 1) < 43)   return exp_cis(int'(a >> 1));
    return 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic release_bus();
    host_reg_n = 1'b1; host_ce1_n = 1'b1; host_ce2_n = 1'b1;
    host_oe_n  = 1'b1; host_we_n  = 1'b1;
  endtask

  // Full read with timing checks on both edges of the access (R2, R3, R4)
  task automatic rd_check(input logic [AW-1:0] a, input logic reg_n,
                          input logic ce1_n, input logic ce2_n, input string req);
    logic en_lo, en_hi;
    logic [7:0] e;
    en_lo = !reg_n && !ce1_n;
    en_hi = en_lo && !ce2_n;
    e = exp_byte(a);
    @(negedge clk);
    host_addr = a; host_reg_n = reg_n; host_ce1_n = ce1_n;
    host_ce2_n = ce2_n; host_oe_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(host_rdata_oe_lo == 1'b0, "R4 early enable", host_rdata_oe_lo, 0);
    @(negedge clk);
    chk(host_rdata_oe_lo == en_lo, {req, " R2 lo enable"}, host_rdata_oe_lo, en_lo);
    chk(host_rdata_oe_hi == en_hi, {req, " R3 hi enable"}, host_rdata_oe_hi, en_hi);
    if (en_lo)
      chk(host_rdata[7:0] == e, {req, " data"}, host_rdata[7:0], e);
    if (en_hi)
      chk(host_rdata[15:8] == 8'h00, "R3 hi byte", host_rdata[15:8], 0);
    release_bus();
    repeat (2) @(negedge clk);
    chk(host_rdata_oe_lo == en_lo, "R4 enable held after release", host_rdata_oe_lo, en_lo);
    @(negedge clk);
    chk(!host_rdata_oe_lo && !host_rdata_oe_hi, "R4 enable drop",
        {host_rdata_oe_hi, host_rdata_oe_lo}, 0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input logic reg_n, input logic ce1_n, input logic oe_n);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_reg_n = reg_n; host_ce1_n = ce1_n;
    host_ce2_n = 1'b1; host_oe_n = oe_n;
    @(negedge clk);
    host_we_n = 1'b0;
    repeat (4) @(negedge clk);
    host_we_n = 1'b1;
    @(negedge clk);
    release_bus();
    repeat (4) @(negedge clk);
    if (!reg_n && !ce1_n && oe_n && a == 12'h200) cor_model = d;
  endtask

  task automatic cfg_check(input string req);
    chk(cfg_index == cor_model[5:0], {req, " cfg_index"}, cfg_index, cor_model[5:0]);
    chk(io_enable == (cor_model[5:0] == 6'd1), {req, " R8 io_enable"}, io_enable,
        (cor_model[5:0] == 6'd1));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!host_rdata_oe_lo && !host_rdata_oe_hi, "R1 enables in reset",
        {host_rdata_oe_hi, host_rdata_oe_lo}, 0);
    chk(cfg_index == 0 && !io_enable, "R1 cfg in reset", {io_enable, cfg_index}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!host_rdata_oe_lo && cfg_index == 0 && !io_enable, "R1 after reset",
        {host_rdata_oe_lo, io_enable, cfg_index}, 0);

    // R5 / R6 sweep of low attribute space, 16-bit reads
    for (int a = 0; a < 128; a++)
      rd_check(AW'(a), 1'b0, 1'b0, 1'b0, (a % 2) ? "R6" : "R5");
    // R6 beyond structure and near register
    rd_check(12'h201, 1'b0, 1'b0, 1'b0, "R6 odd at register");
    rd_check(12'h202, 1'b0, 1'b0, 1'b0, "R6 past register");
    rd_check(12'h1FE, 1'b0, 1'b0, 1'b0, "R6 below register");
    rd_check(12'hFFE, 1'b0, 1'b0, 1'b0, "R6 top");
    // R2 / R3 select variants
    rd_check(12'h004, 1'b1, 1'b0, 1'b0, "R2 REG# high");
    rd_check(12'h004, 1'b0, 1'b1, 1'b0, "R2 CE1# high");
    rd_check(12'h004, 1'b0, 1'b0, 1'b1, "R3 low lane only");
    rd_check(12'h200, 1'b0, 1'b0, 1'b0, "R7 register after reset");

    // R7 / R8 every register value
    for (int v = 0; v < 256; v++) begin
      wr(12'h200, 8'(v), 1'b0, 1'b0, 1'b1);
      cfg_check("R7");
      if (v % 16 == 5) rd_check(12'h200, 1'b0, 1'b0, 1'b1, "R7 readback");
    end

    // R9 rejected writes after a distinctive value
    wr(12'h200, 8'hA7, 1'b0, 1'b0, 1'b1);
    cfg_check("R9 setup");
    wr(12'h200, 8'h01, 1'b1, 1'b0, 1'b1);
    cfg_check("R9 REG# high");
    rd_check(12'h200, 1'b0, 1'b0, 1'b0, "R9 REG# high readback");
    wr(12'h200, 8'h01, 1'b0, 1'b1, 1'b1);
    cfg_check("R9 CE1# high");
    rd_check(12'h200, 1'b0, 1'b0, 1'b0, "R9 CE1# high readback");
    wr(12'h202, 8'h01, 1'b0, 1'b0, 1'b1);
    cfg_check("R9 wrong address");
    rd_check(12'h200, 1'b0, 1'b0, 1'b0, "R9 wrong address readback");
    wr(12'h000, 8'h01, 1'b0, 1'b0, 1'b1);
    cfg_check("R9 structure address");
    wr(12'h200, 8'h01, 1'b0, 1'b0, 1'b0);
    cfg_check("R9 OE# low");
    rd_check(12'h200, 1'b0, 1'b0, 1'b0, "R9 OE# low readback");
    rd_check(12'h000, 1'b0, 1'b0, 1'b0, "R9 structure intact");

    // R10 reset clears written register
    wr(12'h200, 8'h01, 1'b0, 1'b0, 1'b1);
    cfg_check("R10 before reset");
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    cor_model = 8'h00;
    @(negedge clk);
    chk(cfg_index == 0 && !io_enable, "R10 cleared", {io_enable, cfg_index}, 0);
    rd_check(12'h200, 1'b0, 1'b0, 1'b0, "R10 readback");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule